// File: doc/BRIEF.md
# Single-Level Prioritised Interrupt Controller

This block gathers interrupt requests from a set of peripheral lines, picks one of them by fixed priority and raises a single request towards the processor. When the processor answers with an acknowledge pulse, the controller drives the vector number of the chosen line for that one cycle. It then marks the line as in service and forwards nothing more until the handler sends an end-of-interrupt command through a small I/O write port.

Each line is rising-edge sensitive. An edge is held in a pending register until that line is acknowledged. Edges that arrive while a handler runs are kept pending and are forwarded once the end-of-interrupt command arrives. There is only one service level: at most one line is ever in service. The vector base, the command port address and the command code are parameters.

Top module: `sirq_ctrl`

## Requirements
- R1: While reset is held and just after it, `intr` is 0 and `vec_out` is 0.
- R2: A 0-to-1 transition on `irq_line[i]` makes line i pending. `intr` rises on the clock edge that samples the transition. A line held high does not become pending again until it has gone low and risen again.
- R3: When several lines are pending, the one with the lowest index is acknowledged first.
- R4: In a cycle where `inta` is 1 and `intr` is 1, `vec_out` equals VEC_BASE (default 8) plus the index of the selected line, so line 0 (the system timer) gives 8. In every other cycle `vec_out` is 0.
- R5: Starting with the clock edge that takes an acknowledge, `intr` stays 0 until an end-of-interrupt command has been taken, even if other lines are pending.
- R6: An end-of-interrupt command is a cycle with `io_wr` = 1, `io_addr` = 0x20 and `io_data` = 0x20. A write with any other address or data leaves the service state unchanged.
- R7: After an end-of-interrupt command, a request that is still pending drives `intr` to 1 on the same clock edge that takes the command.
- R8: An acknowledge clears only the pending bit of the selected line. All other pending lines stay pending.
- R9: An `inta` pulse while `intr` is 0 has no effect: `vec_out` stays 0 and no line enters service.
- R10: Rising edges that arrive while a line is in service are latched and not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | N_LINES (8) | Peripheral request lines, rising-edge sensitive |
| inta | input | 1 | Processor acknowledge, one cycle per acknowledge |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O write address |
| io_data | input | 8 | I/O write data |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number, non-zero only in the acknowledge cycle |

## Verification
The assertions assume the processor gives exactly one cycle of `inta` for each acknowledge. They also assume that the request lines and the I/O port are synchronous to `clk`. The stimulus drives all inputs half a cycle away from the sampling edge and never stretches `inta` beyond one cycle. Spurious acknowledges happen only while `intr` is low, and the bench uses them on purpose to test that they are ignored. End-of-interrupt writes and decoy writes are each one cycle long.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int unsigned DEF_LINES    = 8;
    localparam int unsigned DEF_VEC_BASE = 8;
    localparam int unsigned DEF_EOI_PORT = 8'h20;
    localparam int unsigned DEF_EOI_CODE = 8'h20;
    localparam int unsigned IO_W         = 8;
endpackage

// File: rtl/sirq_edge_latch.sv
module sirq_edge_latch #(
    parameter int unsigned N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] clr_mask,
    output logic [N_LINES-1:0] pend
);
    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] pend;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines;
        // a new edge wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_mask) | (lines & ~st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask)));

    // R10
    edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lines & ~st_q.prev) != '0 |=> ((pend & $past(lines & ~st_q.prev)) == $past(lines & ~st_q.prev)));
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] req,
    output logic [N_LINES-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl #(
    parameter int unsigned N_LINES  = sirq_pkg::DEF_LINES,
    parameter int unsigned VEC_BASE = sirq_pkg::DEF_VEC_BASE,
    parameter int unsigned EOI_PORT = sirq_pkg::DEF_EOI_PORT,
    parameter int unsigned EOI_CODE = sirq_pkg::DEF_EOI_CODE
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_line,
    input  logic                      inta,
    input  logic                      io_wr,
    input  logic [sirq_pkg::IO_W-1:0] io_addr,
    input  logic [sirq_pkg::IO_W-1:0] io_data,
    output logic                      intr,
    output logic [7:0]                vec_out
);
    localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    typedef struct packed {
        logic [N_LINES-1:0] insvc;
    } svc_t;

    svc_t st_d, st_q;

    logic [N_LINES-1:0] pend, grant, clr_mask;
    logic [IDX_W-1:0]   idx;
    logic               any, ack_fire, eoi_hit;

    sirq_edge_latch #(.N_LINES(N_LINES)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_line),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    sirq_prio #(.N_LINES(N_LINES)) u_prio (
        .req   (pend),
        .grant (grant),
        .idx   (idx),
        .any   (any)
    );

    always_comb begin
        intr     = any && (st_q.insvc == '0);
        ack_fire = inta && intr;
        eoi_hit  = io_wr && (io_addr == sirq_pkg::IO_W'(EOI_PORT))
                         && (io_data == sirq_pkg::IO_W'(EOI_CODE));
        clr_mask = ack_fire ? grant : '0;
        vec_out  = ack_fire ? 8'(VEC_BASE) + 8'(idx) : 8'h00;

        st_d = st_q;
        if (eoi_hit)  st_d.insvc = '0;
        if (ack_fire) st_d.insvc = st_d.insvc | grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(grant) && (((grant - 1'b1) & pend) == '0) && (any == (grant != '0))));

    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr) |-> (int'(vec_out) >= int'(VEC_BASE) && int'(vec_out) < int'(VEC_BASE + N_LINES)));

    // R9
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr) |-> (vec_out == 8'h00));

    // R5
    quiet_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr) |=> !intr);

    // R5
    single_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.insvc));

    // R6
    insvc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(inta && intr) && !eoi_hit) |=> $stable(st_q.insvc));
endmodule

// File: tb/test_sirq_ctrl.sv
`timescale 1ns/100ps
module test_sirq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_line;
    logic       inta, io_wr;
    logic [7:0] io_addr, io_data;
    logic       intr;
    logic [7:0] vec_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    sirq_ctrl i_sirq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .inta(inta),
        .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
        .intr(intr), .vec_out(vec_out)
    );

    task automatic tick();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk_intr(input logic exp, input string req);
        n_chk++;
        if (intr !== exp) begin
            n_fail++;
            $display("FAIL %s intr actual=%0b expected=%0b", req, intr, exp);
        end
    endtask

    task automatic chk_vec_idle(input string req);
        n_chk++;
        if (vec_out !== 8'h00) begin
            n_fail++;
            $display("FAIL %s vec_out actual=%0d expected=0", req, vec_out);
        end
    endtask

    // driver: queue the expected vector, then pulse inta for one cycle
    task automatic ack(input logic [7:0] exp);
        exp_q.push_back(exp);
        inta = 1'b1;
        tick();
        inta = 1'b0;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_data = d;
        tick();
        io_wr = 1'b0; io_addr = '0; io_data = '0;
    endtask

    // monitor: compare vec_out during every acknowledge cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (inta) begin
                logic [7:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
                n_chk++;
                if (vec_out !== e) begin
                    n_fail++;
                    $display("FAIL R4 vec_out actual=%0d expected=%0d", vec_out, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_line = '0; inta = 1'b0; io_wr = 1'b0; io_addr = '0; io_data = '0;
        tick(); tick();
        chk_intr(1'b0, "R1");
        chk_vec_idle("R1");
        rst_n = 1'b1;
        tick();
        chk_intr(1'b0, "R1");

        // R2: edge on line 3
        irq_line = 8'h08; tick();
        chk_intr(1'b1, "R2");
        ack(8'd11);
        chk_intr(1'b0, "R5");
        chk_vec_idle("R4");

        // R10: line 1 rises while line 3 in service
        irq_line = 8'h0A; tick();
        chk_intr(1'b0, "R5");

        // R6: decoy writes
        io_write(8'h21, 8'h20);
        chk_intr(1'b0, "R6");
        io_write(8'h20, 8'h21);
        chk_intr(1'b0, "R6");

        // R7: real end-of-interrupt, line 1 still pending
        io_write(8'h20, 8'h20);
        chk_intr(1'b1, "R7");
        ack(8'd9);
        chk_intr(1'b0, "R10");
        io_write(8'h20, 8'h20);
        chk_intr(1'b0, "R2");

        // R3 and R8: three lines rise together
        irq_line = 8'h00; tick();
        irq_line = 8'hB0; tick();
        chk_intr(1'b1, "R2");
        ack(8'd12);
        io_write(8'h20, 8'h20);
        chk_intr(1'b1, "R8");
        ack(8'd13);
        io_write(8'h20, 8'h20);
        chk_intr(1'b1, "R8");
        ack(8'd15);
        io_write(8'h20, 8'h20);
        chk_intr(1'b0, "R3");

        // R9: spurious acknowledge
        ack(8'd0);
        chk_intr(1'b0, "R9");
        chk_vec_idle("R9");

        // R4: timer line 0 maps to vector 8
        irq_line = 8'h00; tick();
        irq_line = 8'h01; tick();
        chk_intr(1'b1, "R4");
        ack(8'd8);
        io_write(8'h20, 8'h20);
        chk_intr(1'b0, "R7");

        tick(); tick();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 leftover actual=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule